// File: doc/BRIEF.md
# Prescaled Reference Timer

This block is a 16-bit up-counting timer behind a small register window. Software sets a prescale divisor, picks a count clock source, and loads a reference value. The counter then advances once per prescaled tick. When the count matches the reference on a tick, a sticky event flag is set. The counter can either restart from zero at that point or keep running and wrap. An interrupt line follows the event flag, gated by an enable bit in the mode register.

Writes take effect at the clock edge that samples them. Read data comes out of a register in the cycle after the read strobe. Clearing the enable bit by a write also wipes the mode and reference registers. Capture input pins and output toggling are not part of this block. The capture register can only be written and read back by software.

Top module: `ref_timer`

## Requirements
- R1: After synchronous reset, the mode, reference, capture, counter and event registers all read zero, and `irq` is low.
- R2: While mode bit 0 is 0, the prescaler and counter stop. The counter keeps its value and changes only through a direct write.
- R3: A mode write with data bit 0 = 0, made while the stored mode bit 0 is 1, leaves both the mode register and the reference register at zero.
- R4: Mode bits 15:8 hold the prescale value P. With clock source 1 (mode bits 2:1 = 01), the counter advances once every P+1 clock cycles.
- R5: With clock source 2 (mode bits 2:1 = 10), the counter advances once every 16·(P+1) clock cycles. Sources 0 and 3 stop counting.
- R6: On a tick where the counter equals the reference, event bit 1 is set. If mode bit 3 = 1, the counter goes to 0. Otherwise it increments and wraps from 0xFFFF to 0.
- R7: The event register clears on write-one. A 1 in data bit k clears event bit k, and a 0 leaves it unchanged. If a set and a clear of bit 1 happen in the same cycle, the set wins. Event bit 0 (capture) is never set by this block.
- R8: `irq` is high in exactly those cycles where the stored mode bit 4 and event bit 1 are both 1.
- R9: The byte offsets are: 0x00 mode, 0x04 reference, 0x08 capture, 0x0C counter (a write loads it), and 0x11 event. Reads of any other offset return 0. `rdata` shows the addressed register in the cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Reference-event interrupt |

## Verification
The count path is tested with several setups:
- the prescaler set to divide by one and by four on the direct clock;
- the extra divide-by-16 stage;
- both invalid clock sources.

These setups separate the divisor arithmetic from the source selection and from the stop condition. Reference matching is tested twice. With restart on, the count must stay at or below the reference. With restart off, a load near 0xFFFF shows the count wrap before the match. Write-one-to-clear is tested with zero, with the wrong bit and with the right bit, while counting is stopped so that no new event interferes. The interrupt gate is tested by enabling it after the event is already pending.

// File: rtl/ref_timer_pkg.sv
package ref_timer_pkg;
  localparam int unsigned OFS_MODE = 32'h00;
  localparam int unsigned OFS_REF  = 32'h04;
  localparam int unsigned OFS_CAP  = 32'h08;
  localparam int unsigned OFS_CNT  = 32'h0C;
  localparam int unsigned OFS_EVT  = 32'h11;

  localparam int unsigned MB_EN      = 0;
  localparam int unsigned MB_RESTART = 3;
  localparam int unsigned MB_IRQEN   = 4;

  typedef enum logic [1:0] {
    SRC_OFF0  = 2'd0,
    SRC_SYS   = 2'd1,
    SRC_DIV16 = 2'd2,
    SRC_OFF3  = 2'd3
  } clk_src_e;
endpackage

// File: rtl/rt_prescaler.sv
module rt_prescaler #(
  parameter int PRE_W   = 8,
  parameter int DIV16_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             use_div16,
  input  logic [PRE_W-1:0] div_val,
  output logic             tick
);
  logic [DIV16_W-1:0] d16_q;
  logic [PRE_W-1:0]   pre_q;
  logic               stage_en;

  assign stage_en = run && (!use_div16 || (&d16_q));
  assign tick     = stage_en && (pre_q >= div_val);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      d16_q <= '0;
      pre_q <= '0;
    end else begin
      if (use_div16) d16_q <= d16_q + 1'b1;
      else           d16_q <= '0;
      if (stage_en) begin
        if (pre_q >= div_val) pre_q <= '0;
        else                  pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rt_counter.sv
module rt_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  input  logic         restart,
  input  logic [W-1:0] ref_val,
  output logic [W-1:0] cnt,
  output logic         hit
);
  assign hit = tick && (cnt == ref_val);

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (tick) begin
      if (hit && restart)  cnt <= '0;
      else                 cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ref_timer.sv
module ref_timer
  import ref_timer_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int DIV16_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int PRE_W = DATA_W - 8;

  logic [DATA_W-1:0] mode_q, ref_q, cap_q, cnt_q;
  logic [1:0]        evt_q;
  logic [31:0]       addr_ext;
  logic              wr_mode, wr_ref, wr_cap, wr_cnt, wr_evt;
  logic              run, tick, ref_hit;
  clk_src_e          src;
  logic [DATA_W-1:0] nxt_mode, nxt_ref, rd_mux;
  logic [1:0]        nxt_evt, evt_clr;

  assign addr_ext = {{(32-ADDR_W){1'b0}}, addr};
  assign wr_mode  = wr_en && (addr_ext == OFS_MODE);
  assign wr_ref   = wr_en && (addr_ext == OFS_REF);
  assign wr_cap   = wr_en && (addr_ext == OFS_CAP);
  assign wr_cnt   = wr_en && (addr_ext == OFS_CNT);
  assign wr_evt   = wr_en && (addr_ext == OFS_EVT);

  assign src = clk_src_e'(mode_q[2:1]);
  assign run = mode_q[MB_EN] && ((src == SRC_SYS) || (src == SRC_DIV16));

  rt_prescaler #(.PRE_W(PRE_W), .DIV16_W(DIV16_W)) u_pre (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .use_div16 (src == SRC_DIV16),
    .div_val   (mode_q[DATA_W-1:8]),
    .tick      (tick)
  );

  rt_counter #(.W(DATA_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (wr_cnt),
    .load_val (wdata),
    .tick     (tick),
    .restart  (mode_q[MB_RESTART]),
    .ref_val  (ref_q),
    .cnt      (cnt_q),
    .hit      (ref_hit)
  );

  always_comb begin
    nxt_mode = mode_q;
    nxt_ref  = ref_q;
    if (wr_mode) begin
      if (mode_q[MB_EN] && !wdata[MB_EN]) begin
        nxt_mode = '0;
        nxt_ref  = '0;
      end else begin
        nxt_mode = wdata;
      end
    end else if (wr_ref) begin
      nxt_ref = wdata;
    end
    evt_clr = wr_evt ? wdata[1:0] : 2'b00;
    nxt_evt = (evt_q & ~evt_clr) | {ref_hit, 1'b0};
  end

  always_comb begin
    case (addr_ext)
      OFS_MODE: rd_mux = mode_q;
      OFS_REF:  rd_mux = ref_q;
      OFS_CAP:  rd_mux = cap_q;
      OFS_CNT:  rd_mux = cnt_q;
      OFS_EVT:  rd_mux = {{(DATA_W-2){1'b0}}, evt_q};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      ref_q  <= '0;
      cap_q  <= '0;
      evt_q  <= '0;
      irq    <= 1'b0;
      rdata  <= '0;
    end else begin
      mode_q <= nxt_mode;
      ref_q  <= nxt_ref;
      if (wr_cap) cap_q <= wdata;
      evt_q  <= nxt_evt;
      irq    <= nxt_mode[MB_IRQEN] && nxt_evt[1];
      if (rd_en) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/rt_checker.sv
module rt_checker
  import ref_timer_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] mode_q,
  input logic [DATA_W-1:0] ref_q,
  input logic [DATA_W-1:0] cnt_q,
  input logic [1:0]        evt_q,
  input logic              ref_hit,
  input logic              irq
);
  logic [31:0] a32;
  logic        cnt_wr, mode_off_wr;
  assign a32         = {{(32-ADDR_W){1'b0}}, addr};
  assign cnt_wr      = wr_en && (a32 == OFS_CNT);
  assign mode_off_wr = wr_en && (a32 == OFS_MODE) && mode_q[MB_EN] && !wdata[MB_EN];

  // R3
  disable_clears_chk: assert property (@(posedge clk) disable iff (rst)
    mode_off_wr |=> (mode_q == '0 && ref_q == '0));

  // R2
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_q[MB_EN] && !cnt_wr) |=> $stable(cnt_q));

  // R7
  no_capture_evt_chk: assert property (@(posedge clk) disable iff (rst)
    !evt_q[0]);

  // R6
  evt_from_match_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(evt_q[1]) |-> $past(ref_hit));

  // R6
  restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_hit && mode_q[MB_RESTART] && !cnt_wr) |=> (cnt_q == '0));

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (mode_q[MB_IRQEN] && evt_q[1]));
endmodule

bind ref_timer rt_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .addr    (addr),
  .wdata   (wdata),
  .mode_q  (mode_q),
  .ref_q   (ref_q),
  .cnt_q   (cnt_q),
  .evt_q   (evt_q),
  .ref_hit (ref_hit),
  .irq     (irq)
);

// File: tb/tb_ref_timer.sv
module tb_ref_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int    n_chk = 0, n_fail = 0;
  bit    done = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  ref_timer dut (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
                 .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  // behavioural reference model
  logic [15:0] m_mode, m_ref, m_cap, m_cnt, m_rdata, m_rd, m_clr;
  logic [1:0]  m_evt;
  logic        m_irq, m_tick, m_hit, m_run, m_stage;
  int          m_pre, m_d16, m_src;

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_ref = 0; m_cap = 0; m_cnt = 0; m_rdata = 0;
      m_evt = 0; m_irq = 0; m_pre = 0; m_d16 = 0;
    end else begin
      m_src  = int'(m_mode[2:1]);
      m_run  = m_mode[0] && (m_src == 1 || m_src == 2);
      m_tick = 0;
      if (!m_run) begin
        m_pre = 0; m_d16 = 0;
      end else begin
        m_stage = (m_src == 1) || (m_d16 == 15);
        m_d16 = (m_src == 2) ? (m_d16 + 1) % 16 : 0;
        if (m_stage) begin
          if (m_pre >= int'(m_mode[15:8])) begin m_pre = 0; m_tick = 1; end
          else m_pre = m_pre + 1;
        end
      end
      m_hit = m_tick && (m_cnt == m_ref);
      case (addr)
        5'h00: m_rd = m_mode;
        5'h04: m_rd = m_ref;
        5'h08: m_rd = m_cap;
        5'h0C: m_rd = m_cnt;
        5'h11: m_rd = {14'd0, m_evt};
        default: m_rd = 0;
      endcase
      if (rd_en) m_rdata = m_rd;
      if (wr_en && addr == 5'h0C) m_cnt = wdata;
      else if (m_tick) m_cnt = (m_hit && m_mode[3]) ? 16'd0 : m_cnt + 16'd1;
      m_clr = (wr_en && addr == 5'h11) ? wdata : 16'd0;
      m_evt = (m_evt & ~m_clr[1:0]) | (m_hit ? 2'b10 : 2'b00);
      if (wr_en && addr == 5'h00) begin
        if (m_mode[0] && !wdata[0]) begin m_mode = 0; m_ref = 0; end
        else m_mode = wdata;
      end
      if (wr_en && addr == 5'h04) m_ref = wdata;
      if (wr_en && addr == 5'h08) m_cap = wdata;
      m_irq = m_mode[4] && m_evt[1];
    end
  end

  // compare against the model on every clock, away from the edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      n_chk++;
      if (irq !== m_irq) begin
        n_fail++;
        $display("FAIL R8 (%s) irq actual=%0b expected=%0b", cur_req, irq, m_irq);
      end
      n_chk++;
      if (rdata !== m_rdata) begin
        n_fail++;
        $display("FAIL R9 (%s) rdata actual=%h expected=%h", cur_req, rdata, m_rdata);
      end
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  logic [15:0] v, v2;

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    cur_req = "R1";
    check("R1 irq", {15'd0, irq}, 16'd0);
    rd(5'h00, v); check("R1 mode", v, 16'h0000);
    rd(5'h04, v); check("R1 ref", v, 16'h0000);
    rd(5'h08, v); check("R1 cap", v, 16'h0000);
    rd(5'h0C, v); check("R1 cnt", v, 16'h0000);
    rd(5'h11, v); check("R1 evt", v, 16'h0000);

    cur_req = "R9";
    wr(5'h08, 16'hBEEF); rd(5'h08, v); check("R9 capture rw", v, 16'hBEEF);
    rd(5'h01, v); check("R9 unmapped 0x01", v, 16'h0000);
    rd(5'h10, v); check("R9 unmapped 0x10", v, 16'h0000);
    rd(5'h1C, v); check("R9 unmapped 0x1C", v, 16'h0000);
    wr(5'h0C, 16'h1234); rd(5'h0C, v); check("R9 counter load", v, 16'h1234);

    cur_req = "R2";
    wr(5'h00, 16'h0302);
    idle(20);
    rd(5'h0C, v); check("R2 held while disabled", v, 16'h1234);

    cur_req = "R4";
    wr(5'h04, 16'hFFFF);
    wr(5'h0C, 16'h0000);
    wr(5'h00, 16'h0303);
    idle(40);
    rd(5'h0C, v); check("R4 div4 count advanced", {15'd0, (v >= 16'd9 && v <= 16'd11)}, 16'd1);

    cur_req = "R5";
    wr(5'h00, 16'h0301);
    rd(5'h0C, v); idle(10); rd(5'h0C, v2); check("R5 source 0 stops", v2, v);
    wr(5'h00, 16'h0307);
    rd(5'h0C, v); idle(10); rd(5'h0C, v2); check("R5 source 3 stops", v2, v);
    wr(5'h00, 16'h0005);
    wr(5'h0C, 16'h0000);
    idle(64);
    rd(5'h0C, v); check("R5 div16 count", {15'd0, (v >= 16'd3 && v <= 16'd5)}, 16'd1);

    cur_req = "R6";
    wr(5'h00, 16'h0000);
    wr(5'h11, 16'h0003);
    wr(5'h04, 16'h0003);
    wr(5'h0C, 16'h0000);
    wr(5'h00, 16'h001B);
    idle(30);
    rd(5'h11, v); check("R6 ref event set", v, 16'h0002);
    check("R8 irq with enable", {15'd0, irq}, 16'd1);
    rd(5'h0C, v); check("R6 restart bound", {15'd0, (v <= 16'd3)}, 16'd1);

    cur_req = "R7";
    wr(5'h00, 16'h0019);
    wr(5'h11, 16'h0000); rd(5'h11, v); check("R7 write zero keeps", v, 16'h0002);
    wr(5'h11, 16'h0001); rd(5'h11, v); check("R7 other bit keeps", v, 16'h0002);
    wr(5'h11, 16'h0002); rd(5'h11, v); check("R7 write one clears", v, 16'h0000);
    check("R8 irq drops", {15'd0, irq}, 16'd0);

    cur_req = "R8";
    wr(5'h00, 16'h000B);
    idle(20);
    rd(5'h11, v); check("R8 event pending", v, 16'h0002);
    check("R8 irq masked", {15'd0, irq}, 16'd0);
    wr(5'h00, 16'h001B);
    check("R8 irq after enable", {15'd0, irq}, 16'd1);

    cur_req = "R6";
    wr(5'h00, 16'h0000);
    wr(5'h11, 16'h0002);
    wr(5'h04, 16'h0002);
    wr(5'h0C, 16'hFFFD);
    wr(5'h00, 16'h0003);
    idle(10);
    rd(5'h11, v); check("R6 event after wrap", v, 16'h0002);
    rd(5'h0C, v); check("R6 no restart passes ref", {15'd0, (v > 16'd2 && v < 16'd20)}, 16'd1);

    cur_req = "R3";
    wr(5'h04, 16'h1234);
    wr(5'h00, 16'h0010);
    rd(5'h00, v); check("R3 mode cleared", v, 16'h0000);
    rd(5'h04, v); check("R3 ref cleared", v, 16'h0000);

    idle(4);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule